// File: doc/BRIEF.md
# PHY Quick-Status Interrupt Register

This block is a 16-bit status word for the management side of an Ethernet PHY. The PHY datapath reports events and live conditions on plain input wires. The register latches the events until management software reads the word. Some bits are sticky, one bit is latch-low, and two 3-bit fields hold the smallest and largest autonegotiation state codes seen since the last read. A read returns the current value. On the next clock edge the read clears the held events and re-arms the tracking fields. An event that arrives in the same cycle as the read is kept for the next read.

Two bits can be written. The configuration bit selects the meaning of bit 14 and the interrupt rule. The mask bit silences the interrupt. The interrupt output is a level signal. It is high while its condition holds in the stored bits and falls after the read that clears them. Link status resets to 0, so with the default configuration the interrupt output is high after reset until a read re-arms bit 11 while the link is up.

Top module: `phy_qstat_reg`

## Requirements
- R1: Bit 15 sets when `ev_rx_err` is high in a cycle where `speed_100` is 1. It stays set until a read and is 0 after reset. At 10 Mb/s the event is ignored.
- R2: When bit 7 is 0, bit 14 sets when `ev_false_carrier` is high with `speed_100` at 1, and stays set until a read.
- R3: When bit 7 is 1, bit 14 sets in any cycle where `link_up` differs from its value on the previous clock (that value is 0 after reset). It stays set until a read.
- R4: Bit 13 (remote fault) and bit 12 (descrambler unlock or jabber) set on `ev_remote_fault` and `ev_unlock_jabber` respectively. Each stays set until a read.
- R5: Bit 11 is 0 after reset. It goes to 0 one clock after `link_up` is low and stays 0 until a read. A read loads it with the live `link_up` value.
- R6: Bits 10, 9 and 8 show the live values of `partner_pause`, `speed_100` and `full_duplex`, with no register in the path.
- R7: A write (`wr_stb`) loads bit 7 from `wr_data[7]` and bit 6 from `wr_data[6]`, each 0 after reset. The write has no effect on any other bit.
- R8: When bit 7 is 0 and bit 6 is 0, `irq` is high exactly when any of bits 15 to 12 is 1 or bit 11 is 0.
- R9: When bit 7 is 1 and bit 6 is 0, `irq` equals bit 14.
- R10: When bit 6 is 1, `irq` is 0 whatever the other bits hold.
- R11: Bits 5:3 hold the minimum and bits 2:0 hold the maximum of `an_state` over the cycles since the last read. The codes run 0 (enable) to 7 (link good). A read reloads both fields with the `an_state` of the read cycle. Reset sets the fields to 7 and 0, so from the first clock after reset they hold the current state.
- R12: `rd_data` in the cycle of `rd_stb` shows the value before the clear. An event present in that same cycle appears in the word after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read; clears held bits at the clock edge |
| wr_stb | input | 1 | One-cycle write of the control bits |
| wr_data | input | 16 | Write value; only bits 7 and 6 are used |
| ev_rx_err | input | 1 | Receive error event |
| ev_false_carrier | input | 1 | False carrier event |
| ev_remote_fault | input | 1 | Remote fault event |
| ev_unlock_jabber | input | 1 | Descrambler unlock (100 Mb/s) or jabber (10 Mb/s) event |
| link_up | input | 1 | Live link status |
| partner_pause | input | 1 | Link partner supports pause |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| an_state | input | 3 | Current autonegotiation state code |
| rd_data | output | 16 | Register value |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker enforces these rules on every cycle:
- a 100 Mb/s receive error shows in bit 15 on the next cycle;
- a held fault persists while no read occurs;
- a low link clears bit 11 on the next cycle;
- a write lands in bits 7:6;
- the mask forces `irq` low, and with bit 7 set `irq` follows bit 14;
- a read reloads both state fields.

Other behaviour shows only in the bench's scenarios, which compare a behavioural model on every clock. These include the running minimum and maximum over a walk of state codes, events ignored at 10 Mb/s, and writes with the other data bits set leaving those bits unchanged. They also cover bit 14 changing meaning when the configuration is switched, and an event arriving in the same cycle as a read being kept for the following read.

// File: rtl/qs_pkg.sv
package qs_pkg;
    localparam int REG_W      = 16;
    localparam int AN_W       = 3;
    localparam int NUM_STICKY = 4;

    // Bit positions of the status word
    localparam int B_RXERR = 15;
    localparam int B_EV14  = 14;
    localparam int B_RFLT  = 13;
    localparam int B_UJAB  = 12;
    localparam int B_LINK  = 11;
    localparam int B_PAUSE = 10;
    localparam int B_SPD   = 9;
    localparam int B_DUP   = 8;
    localparam int B_CFG   = 7;
    localparam int B_MASK  = 6;
    localparam int LO_LSB  = 3;
    localparam int HI_LSB  = 0;

    // Indices inside the sticky bank; the bank maps onto bits 15:12
    localparam int S_UJAB  = 0;
    localparam int S_RFLT  = 1;
    localparam int S_EV14  = 2;
    localparam int S_RXERR = 3;

    typedef struct packed {
        logic cfg;
        logic mask;
        logic link;
        logic link_prev;
    } ctl_t;

    typedef struct packed {
        logic [AN_W-1:0] lo;
        logic [AN_W-1:0] hi;
    } an_t;
endpackage

// File: rtl/qs_sticky_bank.sv
module qs_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d;
    logic [N-1:0] flags_q;

    // Read clears old content but keeps events arriving in the read cycle
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            flags_d[i] = clr ? set[i] : (flags_q[i] | set[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/qs_an_track.sv
module qs_an_track
    import qs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic [AN_W-1:0] an_state,
    output logic [AN_W-1:0] lo,
    output logic [AN_W-1:0] hi
);
    an_t trk_d;
    an_t trk_q;

    always_comb begin
        trk_d = trk_q;
        if (reload) begin
            trk_d.lo = an_state;
            trk_d.hi = an_state;
        end else begin
            if (an_state < trk_q.lo) trk_d.lo = an_state;
            if (an_state > trk_q.hi) trk_d.hi = an_state;
        end
    end

    // Extreme reset values make the first tracked cycle adopt the live state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.lo <= '1;
            trk_q.hi <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign lo = trk_q.lo;
    assign hi = trk_q.hi;
endmodule

// File: rtl/qs_irq_gen.sv
module qs_irq_gen
    import qs_pkg::*;
(
    input  logic                  cfg,
    input  logic                  mask,
    input  logic [NUM_STICKY-1:0] sticky,
    input  logic                  link,
    output logic                  irq
);
    logic cond_all;
    logic cond_link;

    always_comb begin
        cond_all  = (|sticky) | ~link;
        cond_link = sticky[S_EV14];
        irq       = ~mask & (cfg ? cond_link : cond_all);
    end
endmodule

// File: rtl/phy_qstat_reg.sv
module phy_qstat_reg
    import qs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ev_rx_err,
    input  logic             ev_false_carrier,
    input  logic             ev_remote_fault,
    input  logic             ev_unlock_jabber,
    input  logic             link_up,
    input  logic             partner_pause,
    input  logic             speed_100,
    input  logic             full_duplex,
    input  logic [AN_W-1:0]  an_state,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    ctl_t                  ctl_d;
    ctl_t                  ctl_q;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky;
    logic [AN_W-1:0]       an_lo;
    logic [AN_W-1:0]       an_hi;
    logic                  link_chg;
    logic                  unused_wr;

    assign unused_wr = ^{wr_data[REG_W-1:B_CFG+1], wr_data[B_MASK-1:0]};

    always_comb begin
        link_chg = link_up ^ ctl_q.link_prev;

        sticky_set          = '0;
        sticky_set[S_RXERR] = ev_rx_err & speed_100;
        sticky_set[S_EV14]  = ctl_q.cfg ? link_chg : (ev_false_carrier & speed_100);
        sticky_set[S_RFLT]  = ev_remote_fault;
        sticky_set[S_UJAB]  = ev_unlock_jabber;

        ctl_d           = ctl_q;
        ctl_d.link_prev = link_up;
        ctl_d.link      = rd_stb ? link_up : (ctl_q.link & link_up);
        if (wr_stb) begin
            ctl_d.cfg  = wr_data[B_CFG];
            ctl_d.mask = wr_data[B_MASK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    qs_sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_stb),
        .set   (sticky_set),
        .flags (sticky)
    );

    qs_an_track u_an (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (rd_stb),
        .an_state (an_state),
        .lo       (an_lo),
        .hi       (an_hi)
    );

    qs_irq_gen u_irq (
        .cfg    (ctl_q.cfg),
        .mask   (ctl_q.mask),
        .sticky (sticky),
        .link   (ctl_q.link),
        .irq    (irq)
    );

    always_comb begin
        rd_data                        = '0;
        rd_data[B_RXERR:B_UJAB]        = sticky;
        rd_data[B_LINK]                = ctl_q.link;
        rd_data[B_PAUSE]               = partner_pause;
        rd_data[B_SPD]                 = speed_100;
        rd_data[B_DUP]                 = full_duplex;
        rd_data[B_CFG]                 = ctl_q.cfg;
        rd_data[B_MASK]                = ctl_q.mask;
        rd_data[LO_LSB +: AN_W]        = an_lo;
        rd_data[HI_LSB +: AN_W]        = an_hi;
    end
endmodule

// File: rtl/qs_checker.sv
module qs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [15:0] wr_data,
    input logic        ev_rx_err,
    input logic        speed_100,
    input logic        link_up,
    input logic [2:0]  an_state,
    input logic [15:0] rd_data,
    input logic        irq
);
    a_r1_rxerr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_err && speed_100) |=> rd_data[15]);

    a_r4_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[13] && !rd_stb) |=> rd_data[13]);

    a_r5_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !rd_data[11]);

    a_r7_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (rd_data[7:6] == $past(wr_data[7:6])));

    a_r9_link_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !rd_data[6]) |-> (irq == rd_data[14]));

    a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] |-> !irq);

    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> ((rd_data[5:3] == $past(an_state)) && (rd_data[2:0] == $past(an_state))));

    a_r12_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ev_rx_err && speed_100) |=> rd_data[15]);
endmodule

bind phy_qstat_reg qs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .ev_rx_err (ev_rx_err),
    .speed_100 (speed_100),
    .link_up   (link_up),
    .an_state  (an_state),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/phy_qstat_reg_tb.sv
module phy_qstat_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ev_rx = 1'b0, ev_fc = 1'b0, ev_rf = 1'b0, ev_uj = 1'b0;
    logic        link_up = 1'b0, pause = 1'b0, spd = 1'b0, dup = 1'b0;
    logic [2:0]  an = 3'd0;
    logic [15:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    bit m_rx, m_fc, m_rf, m_uj, m_link, m_cfg, m_mask, m_prev;
    int m_lo, m_hi;

    always #10 clk = ~clk;

    phy_qstat_reg u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .ev_rx_err(ev_rx), .ev_false_carrier(ev_fc), .ev_remote_fault(ev_rf),
        .ev_unlock_jabber(ev_uj), .link_up(link_up), .partner_pause(pause),
        .speed_100(spd), .full_duplex(dup), .an_state(an),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rx = 0; m_fc = 0; m_rf = 0; m_uj = 0; m_link = 0;
        m_cfg = 0; m_mask = 0; m_prev = 0; m_lo = 7; m_hi = 0;
    endtask

    task automatic model_step();
        bit s_rx, s14;
        s_rx = ev_rx && spd;
        s14  = m_cfg ? (link_up != m_prev) : (ev_fc && spd);
        if (rd_stb) begin
            m_rx = s_rx; m_fc = s14; m_rf = ev_rf; m_uj = ev_uj;
            m_link = link_up; m_lo = an; m_hi = an;
        end else begin
            m_rx = m_rx | s_rx; m_fc = m_fc | s14;
            m_rf = m_rf | ev_rf; m_uj = m_uj | ev_uj;
            m_link = m_link & link_up;
            if (int'(an) < m_lo) m_lo = an;
            if (int'(an) > m_hi) m_hi = an;
        end
        m_prev = link_up;
        if (wr_stb) begin
            m_cfg = wr_data[7]; m_mask = wr_data[6];
        end
    endtask

    task automatic compare_all();
        bit    e_irq;
        string t14, tirq;
        t14  = m_cfg ? "R3 link-change bit14" : "R2 false-carrier bit14";
        tirq = m_mask ? "R10 masked irq" : (m_cfg ? "R9 irq link mode" : "R8 irq default mode");
        e_irq = !m_mask && (m_cfg ? m_fc : (m_rx || m_fc || m_rf || m_uj || !m_link));
        chk("R1 rx error bit15", rd_data[15], m_rx);
        chk(t14, rd_data[14], m_fc);
        chk("R4 fault/unlock bits13:12", rd_data[13:12], {m_rf, m_uj});
        chk("R5 latch-low bit11", rd_data[11], m_link);
        chk("R6 live bits10:8", rd_data[10:8], {pause, spd, dup});
        chk("R7 control bits7:6", rd_data[7:6], {m_cfg, m_mask});
        chk("R11 low state bits5:3", rd_data[5:3], m_lo);
        chk("R11 high state bits2:0", rd_data[2:0], m_hi);
        chk(tirq, irq, e_irq);
    endtask

    // inputs are set just after a falling edge; compare, then advance one clock
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    endtask

    task automatic do_write(logic [15:0] v);
        wr_stb = 1'b1; wr_data = v; tick(); wr_stb = 1'b0; wr_data = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        @(posedge clk); @(negedge clk);
        tick();                              // reset state (R1, R5, R7, R11)
        rst_n = 1'b1;
        link_up = 1'b1; spd = 1'b1; dup = 1'b1; pause = 1'b1; an = 3'd2;
        repeat (2) tick();
        do_read();                           // R5 re-arm, R11 reload
        tick();
        // R1 / R2: 100 Mb/s events set, 10 Mb/s ignored
        ev_rx = 1'b1; tick(); ev_rx = 1'b0; tick();
        ev_fc = 1'b1; tick(); ev_fc = 1'b0; tick();
        do_read(); tick();
        spd = 1'b0; dup = 1'b0;              // R6 live change
        ev_rx = 1'b1; ev_fc = 1'b1; tick(); ev_rx = 1'b0; ev_fc = 1'b0; tick();
        // R4
        ev_rf = 1'b1; tick(); ev_rf = 1'b0; ev_uj = 1'b1; tick(); ev_uj = 1'b0;
        repeat (2) tick();
        // R12: read with an event in the same cycle
        spd = 1'b1; ev_rx = 1'b1; do_read(); ev_rx = 1'b0;
        #1 chk("R12 event kept across read", rd_data[15], 1);
        chk("R12 cleared fault after read", rd_data[13], 0);
        tick(); do_read(); tick();
        // R5: link drop and return
        link_up = 1'b0; tick(); link_up = 1'b1; repeat (3) tick();
        do_read(); tick();
        // R11: state walk
        an = 3'd3; tick(); an = 3'd5; tick(); an = 3'd1; tick(); an = 3'd6; tick();
        an = 3'd4; tick();
        do_read(); an = 3'd7; tick(); an = 3'd0; tick();
        do_read(); an = 3'd4; tick(); tick();
        // R7: write all ones -> only control bits move
        do_write(16'hFFFF); repeat (2) tick();
        do_write(16'hFF3F); tick();          // cfg=0 mask=0 with other bits set
        // R3 / R9: link change mode
        do_write(16'h0080); tick();
        link_up = 1'b0; tick(); link_up = 1'b1; tick(); tick();
        ev_fc = 1'b1; ev_rf = 1'b1; tick(); ev_fc = 1'b0; ev_rf = 1'b0; tick();
        do_read(); repeat (2) tick();
        // R10: mask suppresses every source
        do_write(16'h0040);
        ev_uj = 1'b1; link_up = 1'b0; tick(); ev_uj = 1'b0; repeat (2) tick();
        do_write(16'h00C0); link_up = 1'b1; tick(); tick();
        do_write(16'h0000); repeat (2) tick();
        do_read(); repeat (2) tick();
        done = 1;
        summary();
        $finish;
    end
endmodule